// File: doc/BRIEF.md
# Receive Link Bring-Up Sequencer

This block brings up the receive side of a multi-lane serial packet link. A start pulse launches a polling loop. Each poll takes one step of a fixed handshake, then the block waits a programmable delay before the next poll. The handshake has three steps. First, boundary lock is armed on the lanes named by the lane mask. Next, lane alignment is enabled once the lanes report word synchronisation. Finally, receive packet traffic is opened once alignment completes. The block drives one-cycle clear strobes toward the status registers that sit beside it, and it never reads those registers back.

When bring-up succeeds, the sequencer holds link-up and full-duplex high. It also publishes an aggregate rate: the per-lane baud rate in MHz, scaled by the 64/67 coding efficiency and rounded down, times the number of active lanes. Bring-up fails in three cases: the lane mask is empty, alignment reports a failure, or too many polls pass without progress. A failure, or an alignment fault after link-up, takes the link down through a teardown path. That path withdraws the enables and clears the per-lane status of the active lanes if packets had been admitted. A new start is accepted only from idle or from the failed state.

Top module: `rx_link_bringup`

## Requirements
- R1: After reset every enable, strobe, link-up, failed, busy and speed output is zero.
- R2: The first poll after a start with a non-zero lane mask loads boundary-lock-enable with that mask, holds alignment-enable low, and pulses the word-sync clear strobe once.
- R3: A start with an all-zero lane mask ends in the failed state at the first poll, without arming any lane and without any clear strobe.
- R4: Alignment-enable rises, together with a single pulse of the alignment-status clear strobe, only at a poll that finds boundary lock armed and word-sync-done high.
- R5: Consecutive polls are exactly DELAY_CYCLES+1 clock cycles apart.
- R6: At a poll where alignment is enabled and lane-align-fail is high, boundary-lock-enable and alignment-enable are cleared and the failed state is entered, even if lane-align-done is high in the same cycle. Link-up and failed are never high together.
- R7: At a poll where alignment is enabled, lane-align-done is high and lane-align-fail is low, receive packet-enable copies the transmitter's packet-enable bit. The per-lane status clear pulses once with a bit set for each armed lane. Link-up and full-duplex go high.
- R8: While link-up is high, the speed output equals floor(baud*64/67) times the number of set bits in the active lane mask. Otherwise it is zero.
- R9: If no poll succeeds or fails first, the failed state is entered at poll MAX_POLLS+1, that is 1+MAX_POLLS*(DELAY_CYCLES+1) cycles after the edge that samples start. The lane arming is left in place.
- R10: Lane-align-fail while the link is up drops link-up one cycle later. It clears both enables, receive packet-enable and speed, and enters the failed state. If packets were enabled, it pulses the per-lane status clear for the active lanes.
- R11: If receive packet-enable was left low at link-up, a teardown produces no per-lane status clear pulse.
- R12: A start pulse while polling, waiting or up has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin bring-up (accepted in idle or failed) |
| laneMask | input | NLANES | Lanes to bring up |
| wordSyncDone | input | 1 | Word synchronisation reached on the armed lanes |
| alignDone | input | 1 | Lane alignment complete |
| alignFail | input | 1 | Lane alignment failed |
| txPktEn | input | 1 | Transmitter packet-enable bit |
| baudMhz | input | BAUDW | Per-lane baud rate in MHz |
| lockEn | output | NLANES | Boundary-lock enable per lane |
| alignEn | output | 1 | Alignment enable |
| rxPktEn | output | 1 | Receive packet enable |
| wordSyncClr | output | 1 | One-cycle clear of the word-sync status |
| alignStatClr | output | 1 | One-cycle clear of both alignment status bits |
| laneStatClr | output | NLANES | One-cycle clear of each lane's 9-bit status |
| linkUp | output | 1 | Link up |
| fullDuplex | output | 1 | Full duplex, high with link-up |
| failed | output | 1 | Bring-up failed or link torn down |
| busy | output | 1 | Polling or waiting |
| speedMbps | output | BAUDW+clog2(NLANES+1) | Aggregate data rate |

## Verification
Two conditions can reach the same poll. Lane-align-done and lane-align-fail can both be high when the sequencer evaluates alignment, and the fault must win. The bench provokes this by letting the modelled lanes raise both flags together as soon as alignment-enable goes high. It then judges the result at the ports: the failed state must be entered, receive packet-enable must stay low, and no per-lane clear may appear. A start pulse can also land while the sequencer is busy or up. The bench checks that this pulse changes neither the retry timing nor the link state.

// File: rtl/rxlb_pkg.sv
package rxlb_pkg;

  typedef struct packed {
    logic restart;
    logic loadLock;
    logic raiseAlign;
    logic dropLock;
    logic succeed;
    logic teardown;
  } rxlbCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_WAIT,
    ST_UP,
    ST_FAIL
  } rxlbState_e;

endpackage

// File: rtl/rxlb_speed.sv
module rxlb_speed #(
  parameter int NLANES = 16,
  parameter int BAUDW  = 16,
  parameter int SPEEDW = 21
) (
  input  logic [NLANES-1:0] mask,
  input  logic [BAUDW-1:0]  baudMhz,
  output logic [SPEEDW-1:0] speed
);
  localparam int CW = $clog2(NLANES + 1);
  localparam int SW = BAUDW + 6;
  localparam logic [SW-1:0] CODE_DEN = SW'(67);

  logic [CW-1:0] laneCount;
  logic [SW-1:0] scaled;
  logic [SW-1:0] perLane;

  // population count of the active lanes
  always_comb begin
    laneCount = '0;
    for (int i = 0; i < NLANES; i++) begin
      laneCount = laneCount + CW'(mask[i]);
    end
  end

  // 64/67 coding efficiency: multiply by 64 first, then divide
  assign scaled  = {baudMhz, 6'b000000};
  assign perLane = scaled / CODE_DEN;
  assign speed   = SPEEDW'(perLane) * SPEEDW'(laneCount);

endmodule

// File: rtl/rxlb_ctrl.sv
module rxlb_ctrl
  import rxlb_pkg::*;
#(
  parameter int MAX_POLLS    = 200,
  parameter int DELAY_CYCLES = 5000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     wordSyncDone,
  input  logic     alignDone,
  input  logic     alignFail,
  input  logic     maskAny,
  input  logic     lockAny,
  input  logic     alignOn,
  output rxlbCtl_t ctl,
  output logic     linkUp,
  output logic     failed,
  output logic     busy
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int DW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [PW-1:0] POLL_LIMIT = PW'(MAX_POLLS);
  localparam logic [DW-1:0] DELAY_LOAD = DW'(DELAY_CYCLES - 1);

  rxlbState_e    state, stateN;
  logic [PW-1:0] pollCnt, pollCntN;
  logic [DW-1:0] waitCnt, waitCntN;

  always_comb begin
    stateN   = state;
    pollCntN = pollCnt;
    waitCntN = waitCnt;
    ctl      = '0;
    case (state)
      ST_IDLE, ST_FAIL: begin
        if (start) begin
          ctl.restart = 1'b1;
          pollCntN    = '0;
          stateN      = ST_POLL;
        end
      end
      ST_POLL: begin
        waitCntN = DELAY_LOAD;
        if (pollCnt == POLL_LIMIT) begin
          // retry budget exhausted
          ctl.teardown = 1'b1;
          stateN       = ST_FAIL;
        end else begin
          pollCntN = pollCnt + 1'b1;
          if (!lockAny) begin
            if (!maskAny) begin
              ctl.teardown = 1'b1;
              stateN       = ST_FAIL;
            end else begin
              ctl.loadLock = 1'b1;
              stateN       = ST_WAIT;
            end
          end else if (!alignOn) begin
            ctl.raiseAlign = wordSyncDone;
            stateN         = ST_WAIT;
          end else if (alignFail) begin
            ctl.dropLock = 1'b1;
            ctl.teardown = 1'b1;
            stateN       = ST_FAIL;
          end else if (alignDone) begin
            ctl.succeed = 1'b1;
            stateN      = ST_UP;
          end else begin
            stateN = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (waitCnt == '0) stateN = ST_POLL;
        else               waitCntN = waitCnt - 1'b1;
      end
      ST_UP: begin
        if (alignFail) begin
          ctl.dropLock = 1'b1;
          ctl.teardown = 1'b1;
          stateN       = ST_FAIL;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pollCnt <= '0;
      waitCnt <= '0;
    end else begin
      state   <= stateN;
      pollCnt <= pollCntN;
      waitCnt <= waitCntN;
    end
  end

  assign linkUp = (state == ST_UP);
  assign failed = (state == ST_FAIL);
  assign busy   = (state == ST_POLL) || (state == ST_WAIT);

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && waitCnt != '0) |=> state == ST_WAIT); // R5
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL && pollCnt == POLL_LIMIT) |=> state == ST_FAIL); // R9
  AST_UP_FAULT_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UP && alignFail) |=> state == ST_FAIL); // R10
  AST_START_IGNORED_UP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UP && !alignFail) |=> state == ST_UP); // R12

endmodule

// File: rtl/rxlb_datapath.sv
module rxlb_datapath
  import rxlb_pkg::*;
#(
  parameter int NLANES = 16,
  parameter int BAUDW  = 16,
  parameter int SPEEDW = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxlbCtl_t          ctl,
  input  logic [NLANES-1:0] laneMask,
  input  logic              txPktEn,
  input  logic [BAUDW-1:0]  baudMhz,
  output logic [NLANES-1:0] lockEn,
  output logic              alignEn,
  output logic              rxPktEn,
  output logic              wsClr,
  output logic              asClr,
  output logic [NLANES-1:0] laneClr,
  output logic [SPEEDW-1:0] speed
);
  logic [NLANES-1:0] activeMask;
  logic [SPEEDW-1:0] speedCalc;

  rxlb_speed #(.NLANES(NLANES), .BAUDW(BAUDW), .SPEEDW(SPEEDW)) u_speed (
    .mask    (lockEn),
    .baudMhz (baudMhz),
    .speed   (speedCalc)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockEn     <= '0;
      alignEn    <= 1'b0;
      rxPktEn    <= 1'b0;
      activeMask <= '0;
      speed      <= '0;
      wsClr      <= 1'b0;
      asClr      <= 1'b0;
      laneClr    <= '0;
    end else begin
      wsClr   <= 1'b0;
      asClr   <= 1'b0;
      laneClr <= '0;
      if (ctl.restart) begin
        lockEn     <= '0;
        alignEn    <= 1'b0;
        rxPktEn    <= 1'b0;
        activeMask <= '0;
        speed      <= '0;
      end
      if (ctl.loadLock) begin
        lockEn  <= laneMask;
        alignEn <= 1'b0;
        wsClr   <= 1'b1;
      end
      if (ctl.raiseAlign) begin
        alignEn <= 1'b1;
        asClr   <= 1'b1;
      end
      if (ctl.succeed) begin
        rxPktEn    <= txPktEn;
        activeMask <= lockEn;
        laneClr    <= lockEn;
        speed      <= speedCalc;
      end
      if (ctl.dropLock) begin
        lockEn  <= '0;
        alignEn <= 1'b0;
      end
      if (ctl.teardown) begin
        speed <= '0;
        if (rxPktEn) begin
          rxPktEn <= 1'b0;
          laneClr <= activeMask;
        end
      end
    end
  end

  AST_ALIGN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    alignEn |-> lockEn != '0); // R4
  AST_PKT_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    rxPktEn |-> alignEn); // R7
  AST_LOCK_TAKES_MASK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLock |=> (lockEn == $past(laneMask)) && wsClr); // R2
  AST_CLEARS_APART: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wsClr, asClr, |laneClr})); // R7
  AST_TEARDOWN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.teardown |=> !rxPktEn && speed == '0); // R10

endmodule

// File: rtl/rx_link_bringup.sv
module rx_link_bringup
  import rxlb_pkg::*;
#(
  parameter int NLANES       = 16,
  parameter int BAUDW        = 16,
  parameter int MAX_POLLS    = 200,
  parameter int DELAY_CYCLES = 5000
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 start,
  input  logic [NLANES-1:0]                    laneMask,
  input  logic                                 wordSyncDone,
  input  logic                                 alignDone,
  input  logic                                 alignFail,
  input  logic                                 txPktEn,
  input  logic [BAUDW-1:0]                     baudMhz,
  output logic [NLANES-1:0]                    lockEn,
  output logic                                 alignEn,
  output logic                                 rxPktEn,
  output logic                                 wordSyncClr,
  output logic                                 alignStatClr,
  output logic [NLANES-1:0]                    laneStatClr,
  output logic                                 linkUp,
  output logic                                 fullDuplex,
  output logic                                 failed,
  output logic                                 busy,
  output logic [BAUDW+$clog2(NLANES+1)-1:0]    speedMbps
);
  localparam int SPEEDW = BAUDW + $clog2(NLANES + 1);

  rxlbCtl_t ctl;

  rxlb_ctrl #(.MAX_POLLS(MAX_POLLS), .DELAY_CYCLES(DELAY_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .wordSyncDone (wordSyncDone),
    .alignDone    (alignDone),
    .alignFail    (alignFail),
    .maskAny      (|laneMask),
    .lockAny      (|lockEn),
    .alignOn      (alignEn),
    .ctl          (ctl),
    .linkUp       (linkUp),
    .failed       (failed),
    .busy         (busy)
  );

  rxlb_datapath #(.NLANES(NLANES), .BAUDW(BAUDW), .SPEEDW(SPEEDW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .laneMask (laneMask),
    .txPktEn  (txPktEn),
    .baudMhz  (baudMhz),
    .lockEn   (lockEn),
    .alignEn  (alignEn),
    .rxPktEn  (rxPktEn),
    .wsClr    (wordSyncClr),
    .asClr    (alignStatClr),
    .laneClr  (laneStatClr),
    .speed    (speedMbps)
  );

  assign fullDuplex = linkUp;

  AST_UP_XOR_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    !(linkUp && failed)); // R6
  AST_SPEED_ONLY_UP: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |-> speedMbps == '0); // R8

endmodule

// File: tb/rx_link_bringup_bench.sv
module rx_link_bringup_bench;
  localparam int NL = 8;
  localparam int BW = 16;
  localparam int MP = 200;
  localparam int DL = 3;
  localparam int SW = BW + $clog2(NL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NL-1:0] laneMask = '0;
  logic txPktEn = 1'b0;
  logic [BW-1:0] baudMhz = '0;
  logic wordSyncDone, alignDone, alignFail;
  logic [NL-1:0] lockEn, laneStatClr;
  logic alignEn, rxPktEn, wordSyncClr, alignStatClr;
  logic linkUp, fullDuplex, failed, busy;
  logic [SW-1:0] speedMbps;

  bit syncOk = 0, alignOk = 0, alignBad = 0;

  // simple lane model reacting to the enables
  assign wordSyncDone = syncOk && (lockEn != '0);
  assign alignDone    = alignOk && alignEn;
  assign alignFail    = alignBad && alignEn;

  rx_link_bringup #(.NLANES(NL), .BAUDW(BW), .MAX_POLLS(MP), .DELAY_CYCLES(DL)) u_rx_link_bringup (
    .clk(clk), .rstN(rstN), .start(start), .laneMask(laneMask),
    .wordSyncDone(wordSyncDone), .alignDone(alignDone), .alignFail(alignFail),
    .txPktEn(txPktEn), .baudMhz(baudMhz), .lockEn(lockEn), .alignEn(alignEn),
    .rxPktEn(rxPktEn), .wordSyncClr(wordSyncClr), .alignStatClr(alignStatClr),
    .laneStatClr(laneStatClr), .linkUp(linkUp), .fullDuplex(fullDuplex),
    .failed(failed), .busy(busy), .speedMbps(speedMbps)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;
  int wsCnt, asCnt, lcCnt, lcMask, lockCyc, alignCyc, failCyc, startEdge;

  always @(negedge clk) begin
    if (wordSyncClr) wsCnt++;
    if (alignStatClr) asCnt++;
    if (laneStatClr != '0) begin
      lcCnt++;
      lcMask = lcMask | int'(laneStatClr);
    end
    if (lockEn != '0 && lockCyc < 0) lockCyc = cyc;
    if (alignEn && alignCyc < 0) alignCyc = cyc;
    if (failed && failCyc < 0) failCyc = cyc;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expSpeed(input int mask, input int baud);
    int n = 0;
    for (int i = 0; i < NL; i++) n += (mask >> i) & 1;
    return ((baud * 64) / 67) * n;
  endfunction

  task automatic fire();
    @(negedge clk); #1;
    wsCnt = 0; asCnt = 0; lcCnt = 0; lcMask = 0;
    lockCyc = -1; alignCyc = -1; failCyc = -1;
    startEdge = cyc + 1;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitEnd();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(linkUp || failed) && n < 3000);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic runCase(input int mask, input int baud, input bit tx, input bit withFail);
    int es, lcBefore;
    @(negedge clk); #1;
    laneMask = NL'(mask); baudMhz = BW'(baud); txPktEn = tx;
    syncOk = 1; alignOk = 1; alignBad = withFail;
    fire();
    waitEnd();
    if (mask == 0) begin
      check(failed == 1'b1, "R3 failed on empty mask", failed, 1);
      check(wsCnt == 0 && lockEn == '0, "R3 nothing armed", wsCnt, 0);
      check(linkUp == 1'b0, "R3 no link", linkUp, 0);
    end else if (withFail) begin
      check(failed == 1'b1 && linkUp == 1'b0, "R6 fault beats done", failed, 1);
      check(lockEn == '0 && alignEn == 1'b0, "R6 enables dropped", lockEn, 0);
      check(asCnt == 1, "R4 align clear once", asCnt, 1);
      check(lcCnt == 0 && rxPktEn == 1'b0, "R6 no lane clear", lcCnt, 0);
    end else begin
      es = expSpeed(mask, baud);
      check(linkUp && fullDuplex, "R7 link up", linkUp, 1);
      check(rxPktEn == tx, "R7 packet enable copy", rxPktEn, tx);
      check(lcCnt == 1 && lcMask == mask, "R7 lane clear mask", lcMask, mask);
      check(int'(speedMbps) == es, "R8 speed", speedMbps, es);
      check(lockEn == NL'(mask) && wsCnt == 1, "R2 lock armed", lockEn, mask);
      check(asCnt == 1, "R4 align clear once", asCnt, 1);
      check(alignCyc - lockCyc == DL + 1, "R5 poll spacing", alignCyc - lockCyc, DL + 1);
      // start while up is ignored
      @(negedge clk); #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
      repeat (3) @(negedge clk); #1;
      check(linkUp == 1'b1 && wsCnt == 1, "R12 start ignored when up", linkUp, 1);
      // teardown
      lcBefore = lcCnt;
      alignBad = 1;
      repeat (3) @(negedge clk); #1;
      check(failed && !linkUp, "R10 link dropped", linkUp, 0);
      check(!rxPktEn && speedMbps == '0 && lockEn == '0, "R10 teardown cleared", speedMbps, 0);
      if (tx) check(lcCnt == lcBefore + 1 && lcMask == mask, "R10 lane clear on teardown", lcCnt - lcBefore, 1);
      else    check(lcCnt == lcBefore, "R11 no lane clear without packets", lcCnt - lcBefore, 0);
      check(int'(speedMbps) == 0, "R8 speed zero when down", speedMbps, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(lockEn == '0 && !alignEn && !rxPktEn, "R1 enables reset", lockEn, 0);
    check(!linkUp && !failed && !busy && speedMbps == '0, "R1 status reset", linkUp, 0);
    check(!wordSyncClr && !alignStatClr && laneStatClr == '0, "R1 strobes reset", laneStatClr, 0);

    runCase(8'hFF, 25781, 1'b1, 1'b0);
    runCase(8'h01, 10312, 1'b0, 1'b0);
    runCase(0, 6250, 1'b1, 1'b0);
    runCase(8'h3C, 12500, 1'b1, 1'b1);

    // retry budget exhaustion with a start pulse while busy
    @(negedge clk); #1;
    laneMask = 8'h0F; baudMhz = BW'(6250); txPktEn = 1'b1;
    syncOk = 0; alignOk = 1; alignBad = 0;
    fire();
    repeat (40) @(negedge clk);
    #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    waitEnd();
    check(failed == 1'b1, "R9 failed after retries", failed, 1);
    check(failCyc - startEdge == 1 + MP * (DL + 1), "R9 retry timing and R12 busy start ignored",
          failCyc - startEdge, 1 + MP * (DL + 1));
    check(lockEn == 8'h0F && !alignEn, "R9 lock kept", lockEn, 8'h0F);
    check(asCnt == 0 && wsCnt == 1, "R4 no align without sync", asCnt, 0);

    for (int i = 0; i < 14; i++) begin
      int m, b;
      bit t, f;
      m = int'($urandom_range(1, 255));
      if (i % 5 == 4) m = 0;
      b = int'($urandom_range(1000, 28000));
      t = 1'($urandom_range(0, 1));
      f = ($urandom_range(0, 3) == 0);
      runCase(m, b, t, f);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule